// File: doc/BRIEF.md
# Floating-Point NaN-Boxing Unit

This unit sits between a floating-point register file that is FLEN bits wide and the functional units that produce or consume narrower values. On the write path it takes a result, a format code and a valid strobe. It then places the result in the low bits of a full-width register word and fills every bit above the result with ones.

On the read path it takes a register word and the format that the consuming instruction expects. A narrow operand counts as valid only when all of its upper bits are ones. A valid operand is returned as it is. An invalid one is replaced by the canonical quiet NaN of the requested format, boxed in the same way. When the format width equals FLEN, both paths pass the value through unchanged.

A format is legal only if it fits within FLEN and the parameters enable it. Double precision requires single, and quad requires double. An illegal request raises a flag on its own path. The outputs can be combinational, or registered one stage by a parameter.

Top module: `nanbox_unit`

## Requirements
- R1: On a legal write with format width w < FLEN, wr_data_o holds wr_data_i[w-1:0] in bits w-1..0 and ones in every bit from w up to FLEN-1. Format codes: 0 = single (32 bits), 1 = double (64 bits), 2 = quad (128 bits), 3 = reserved.
- R2: On a legal write with format width equal to FLEN, wr_data_o equals wr_data_i.
- R3: On a legal read with width w < FLEN, if rd_data_i bits FLEN-1..w are all ones, then rd_data_o equals rd_data_i and rd_nan_o is 0.
- R4: On a legal read with width w < FLEN, if any bit in FLEN-1..w is zero, then rd_nan_o is 1. In that case rd_data_o carries ones above w and the canonical quiet NaN of the format below w: 0x7FC00000 for single, 0x7FF8000000000000 for double, and 0x7FFF8 followed by 27 hex zeros for quad.
- R5: On a legal read with width equal to FLEN, rd_data_o equals rd_data_i and rd_nan_o is 0.
- R6: A format is illegal when its width exceeds FLEN, when the parameters disable it, or when its code is 3. An illegal format sets the matching illegal flag and forces that path's data to zero. It also forces wr_valid_o to 0 on the write path and rd_nan_o to 0 on the read path.
- R7: wr_valid_o equals wr_valid_i whenever the write format is legal.
- R8: With OUT_REG = 1, every output appears one clock after its inputs and is zero while rst_ni is low. With OUT_REG = 0, the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write result strobe |
| wr_fmt_i | input | 2 | Write format code |
| wr_data_i | input | FLEN | Result from a functional unit, in the low bits |
| wr_valid_o | output | 1 | Strobe toward the register file |
| wr_illegal_o | output | 1 | Write format not supported |
| wr_data_o | output | FLEN | Boxed register word |
| rd_fmt_i | input | 2 | Format the reading instruction expects |
| rd_data_i | input | FLEN | Register word read from the file |
| rd_data_o | output | FLEN | Operand, or boxed canonical NaN |
| rd_nan_o | output | 1 | Operand was replaced by a canonical NaN |
| rd_illegal_o | output | 1 | Read format not supported |

## Verification
The hardest case to reach is a read operand whose upper bits are all ones except for a single zero bit. Random data almost never produces it. It is also the only input that separates an exact all-ones check from a partial one. The stimulus therefore builds valid boxes on purpose and then clears one chosen bit at a time. This includes a bit that lies above the 64-bit view but inside the 128-bit view, so a single word reads as valid at one register width and as invalid at the other. Two instances run side by side: a registered 64-bit unit and a combinational 128-bit unit with quad enabled. Between them they reach full-width passthrough, invalid narrow reads, and every illegal-format path.

// File: rtl/nanbox_pkg.sv
package nanbox_pkg;

  typedef enum logic [1:0] {
    FMT_SGL  = 2'd0,
    FMT_DBL  = 2'd1,
    FMT_QUAD = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;

  function automatic int fmt_bits(fmt_e f);
    case (f)
      FMT_SGL:  return 32;
      FMT_DBL:  return 64;
      FMT_QUAD: return 128;
      default:  return 0;
    endcase
  endfunction

  function automatic int exp_bits(fmt_e f);
    case (f)
      FMT_SGL:  return 8;
      FMT_DBL:  return 11;
      FMT_QUAD: return 15;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/nanbox_fmt_gate.sv
module nanbox_fmt_gate
  import nanbox_pkg::*;
#(
  parameter int FLEN = 64,
  parameter bit EN_D = 1'b1,
  parameter bit EN_Q = 1'b0
) (
  input  logic [1:0] fmt_i,
  output logic       legal_o
);
  // quad implies double implies single
  localparam bit D_OK = EN_D && (FLEN >= 64);
  localparam bit Q_OK = D_OK && EN_Q && (FLEN >= 128);

  always_comb begin
    case (fmt_e'(fmt_i))
      FMT_SGL:  legal_o = 1'b1;
      FMT_DBL:  legal_o = D_OK;
      FMT_QUAD: legal_o = Q_OK;
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nanbox_writer.sv
module nanbox_writer
  import nanbox_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [1:0]      fmt_i,
  input  logic            legal_i,
  input  logic [FLEN-1:0] data_i,
  output logic [FLEN-1:0] data_o
);
  int w;

  always_comb begin
    w = fmt_bits(fmt_e'(fmt_i));
    for (int i = 0; i < FLEN; i++) begin
      if (!legal_i)    data_o[i] = 1'b0;
      else if (i >= w) data_o[i] = 1'b1;
      else             data_o[i] = data_i[i];
    end
  end
endmodule

// File: rtl/nanbox_reader.sv
module nanbox_reader
  import nanbox_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [1:0]      fmt_i,
  input  logic            legal_i,
  input  logic [FLEN-1:0] data_i,
  output logic [FLEN-1:0] data_o,
  output logic            nan_o
);
  int              w;
  int              m;
  logic            boxed_ok;
  logic [FLEN-1:0] canon;

  always_comb begin
    w = fmt_bits(fmt_e'(fmt_i));
    m = w - 1 - exp_bits(fmt_e'(fmt_i));
    boxed_ok = 1'b1;
    for (int i = 0; i < FLEN; i++) begin
      if (i >= w && !data_i[i]) boxed_ok = 1'b0;
      // box ones, clear sign, exponent ones plus quiet bit, rest zero
      if (i >= w)          canon[i] = 1'b1;
      else if (i == w - 1) canon[i] = 1'b0;
      else if (i >= m - 1) canon[i] = 1'b1;
      else                 canon[i] = 1'b0;
    end
    nan_o = legal_i && !boxed_ok;
    if (!legal_i)      data_o = '0;
    else if (boxed_ok) data_o = data_i;
    else               data_o = canon;
  end
endmodule

// File: rtl/nanbox_out_stage.sv
module nanbox_out_stage #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/nanbox_unit.sv
module nanbox_unit #(
  parameter int FLEN    = 64,
  parameter bit EN_D    = 1'b1,
  parameter bit EN_Q    = 1'b0,
  parameter bit OUT_REG = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_valid_i,
  input  logic [1:0]      wr_fmt_i,
  input  logic [FLEN-1:0] wr_data_i,
  output logic            wr_valid_o,
  output logic            wr_illegal_o,
  output logic [FLEN-1:0] wr_data_o,
  input  logic [1:0]      rd_fmt_i,
  input  logic [FLEN-1:0] rd_data_i,
  output logic [FLEN-1:0] rd_data_o,
  output logic            rd_nan_o,
  output logic            rd_illegal_o
);
  localparam int BW = FLEN + 2;

  logic            wr_legal, rd_legal;
  logic [FLEN-1:0] wr_boxed, rd_checked;
  logic            rd_nan;
  logic [BW-1:0]   wr_bundle_d, wr_bundle_q, rd_bundle_d, rd_bundle_q;

  nanbox_fmt_gate #(.FLEN(FLEN), .EN_D(EN_D), .EN_Q(EN_Q)) u_wr_gate (
    .fmt_i   (wr_fmt_i),
    .legal_o (wr_legal)
  );

  nanbox_fmt_gate #(.FLEN(FLEN), .EN_D(EN_D), .EN_Q(EN_Q)) u_rd_gate (
    .fmt_i   (rd_fmt_i),
    .legal_o (rd_legal)
  );

  nanbox_writer #(.FLEN(FLEN)) u_writer (
    .fmt_i   (wr_fmt_i),
    .legal_i (wr_legal),
    .data_i  (wr_data_i),
    .data_o  (wr_boxed)
  );

  nanbox_reader #(.FLEN(FLEN)) u_reader (
    .fmt_i   (rd_fmt_i),
    .legal_i (rd_legal),
    .data_i  (rd_data_i),
    .data_o  (rd_checked),
    .nan_o   (rd_nan)
  );

  assign wr_bundle_d = {wr_valid_i & wr_legal, ~wr_legal, wr_boxed};
  assign rd_bundle_d = {rd_nan, ~rd_legal, rd_checked};

  nanbox_out_stage #(.W(BW), .OUT_REG(OUT_REG)) u_wr_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (wr_bundle_d),
    .q_o    (wr_bundle_q)
  );

  nanbox_out_stage #(.W(BW), .OUT_REG(OUT_REG)) u_rd_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rd_bundle_d),
    .q_o    (rd_bundle_q)
  );

  assign {wr_valid_o, wr_illegal_o, wr_data_o} = wr_bundle_q;
  assign {rd_nan_o, rd_illegal_o, rd_data_o}   = rd_bundle_q;
endmodule

// File: rtl/nanbox_unit_chk.sv
module nanbox_unit_chk #(
  parameter int FLEN    = 64,
  parameter bit EN_D    = 1'b1,
  parameter bit EN_Q    = 1'b0,
  parameter bit OUT_REG = 1'b0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_valid_i,
  input logic            wr_valid_o,
  input logic            wr_illegal_o,
  input logic [FLEN-1:0] wr_data_o,
  input logic [1:0]      rd_fmt_i,
  input logic [FLEN-1:0] rd_data_i,
  input logic [FLEN-1:0] rd_data_o,
  input logic            rd_nan_o,
  input logic            rd_illegal_o
);
  localparam logic [1:0] FULL_CODE = (FLEN == 32) ? 2'd0 : (FLEN == 64) ? 2'd1 : 2'd2;
  localparam bit FULL_OK = (FLEN == 32) || (FLEN == 64 && EN_D) ||
                           (FLEN == 128 && EN_D && EN_Q);

  assert_wr_illegal_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_illegal_o |-> (!wr_valid_o && wr_data_o == '0));

  assert_rd_illegal_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_illegal_o |-> (rd_data_o == '0 && !rd_nan_o));

  assert_nan_top_boxed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_nan_o |-> (rd_data_o[FLEN-1] && !rd_illegal_o));

  if (OUT_REG) begin : g_seq
    assert_idle_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_valid_i |=> !wr_valid_o);
    if (FULL_OK) begin : g_full
      assert_full_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_fmt_i == FULL_CODE) |=> (rd_data_o == $past(rd_data_i) && !rd_nan_o));
    end
  end else begin : g_comb
    assert_idle_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_valid_i |-> !wr_valid_o);
    if (FULL_OK) begin : g_full
      assert_full_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_fmt_i == FULL_CODE) |-> (rd_data_o == rd_data_i && !rd_nan_o));
    end
  end
endmodule

bind nanbox_unit nanbox_unit_chk #(
  .FLEN(FLEN), .EN_D(EN_D), .EN_Q(EN_Q), .OUT_REG(OUT_REG)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .wr_valid_o   (wr_valid_o),
  .wr_illegal_o (wr_illegal_o),
  .wr_data_o    (wr_data_o),
  .rd_fmt_i     (rd_fmt_i),
  .rd_data_i    (rd_data_i),
  .rd_data_o    (rd_data_o),
  .rd_nan_o     (rd_nan_o),
  .rd_illegal_o (rd_illegal_o)
);

// File: tb/nanbox_unit_tb.sv
module nanbox_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid;
  logic [1:0]   wr_fmt, rd_fmt;
  logic [127:0] wr_data, rd_data;

  logic         n_wv, n_wi, n_rn, n_ri;
  logic [63:0]  n_wd, n_rd;
  logic         q_wv, q_wi, q_rn, q_ri;
  logic [127:0] q_wd, q_rd;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // registered 64-bit unit, quad out of range
  nanbox_unit #(.FLEN(64), .EN_D(1'b1), .EN_Q(1'b0), .OUT_REG(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_fmt_i(wr_fmt), .wr_data_i(wr_data[63:0]),
    .wr_valid_o(n_wv), .wr_illegal_o(n_wi), .wr_data_o(n_wd),
    .rd_fmt_i(rd_fmt), .rd_data_i(rd_data[63:0]),
    .rd_data_o(n_rd), .rd_nan_o(n_rn), .rd_illegal_o(n_ri)
  );

  // combinational 128-bit unit, all formats
  nanbox_unit #(.FLEN(128), .EN_D(1'b1), .EN_Q(1'b1), .OUT_REG(1'b0)) u_dut_wide (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_fmt_i(wr_fmt), .wr_data_i(wr_data),
    .wr_valid_o(q_wv), .wr_illegal_o(q_wi), .wr_data_o(q_wd),
    .rd_fmt_i(rd_fmt), .rd_data_i(rd_data),
    .rd_data_o(q_rd), .rd_nan_o(q_rn), .rd_illegal_o(q_ri)
  );

  typedef struct {
    logic         wv, wi, rn, ri;
    logic [127:0] wd, rd;
    string        wtag, rtag;
  } exp_t;

  exp_t exp_n[$];
  exp_t exp_q[$];

  function automatic logic [127:0] ones_below(int n);
    if (n >= 128) return '1;
    return (128'd1 << n) - 128'd1;
  endfunction

  function automatic int width_of(logic [1:0] f);
    case (f)
      2'd0: return 32;
      2'd1: return 64;
      2'd2: return 128;
      default: return 0;
    endcase
  endfunction

  function automatic logic [127:0] qnan_of(int w);
    case (w)
      32: return 128'h7FC00000;
      64: return 128'h7FF8000000000000;
      default: return {32'h7FFF8000, 96'h0};
    endcase
  endfunction

  function automatic exp_t model(int flen, bit en_q);
    exp_t e;
    int   ww, rw;
    logic [127:0] fm;
    fm = ones_below(flen);
    ww = width_of(wr_fmt);
    rw = width_of(rd_fmt);
    e.wv = 1'b0; e.wi = 1'b0; e.rn = 1'b0; e.ri = 1'b0; e.wd = '0; e.rd = '0;
    if (ww == 0 || ww > flen || (ww == 128 && !en_q)) begin
      e.wi = 1'b1; e.wtag = "R6";
    end else begin
      e.wv = wr_valid;
      e.wd = (wr_data & ones_below(ww)) | (fm & ~ones_below(ww));
      e.wtag = (ww < flen) ? "R1" : "R2";
    end
    if (rw == 0 || rw > flen || (rw == 128 && !en_q)) begin
      e.ri = 1'b1; e.rtag = "R6";
    end else if (rw == flen) begin
      e.rd = rd_data & fm; e.rtag = "R5";
    end else if (((rd_data | ones_below(rw)) & fm) == fm) begin
      e.rd = rd_data & fm; e.rtag = "R3";
    end else begin
      e.rn = 1'b1;
      e.rd = (fm & ~ones_below(rw)) | qnan_of(rw);
      e.rtag = "R4";
    end
    return e;
  endfunction

  task automatic chk(string tag, string what, logic [129:0] act, logic [129:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_pending();
    exp_t e;
    if (exp_n.size() > 0) begin
      e = exp_n.pop_front();
      chk(e.wtag, "flen64 write", {n_wi, 65'(n_wd)}, {e.wi, 65'(e.wd[63:0])});
      chk("R7", "flen64 valid", 130'(n_wv), 130'(e.wv));
      chk(e.rtag, "flen64 read", {n_rn, n_ri, 64'(n_rd)}, {e.rn, e.ri, e.rd[63:0]});
    end
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(e.wtag, "flen128 write", {n_wi & 1'b0, q_wi, q_wd}, {1'b0, e.wi, e.wd});
      chk("R7", "flen128 valid", 130'(q_wv), 130'(e.wv));
      chk(e.rtag, "flen128 read", {q_rn, q_ri, q_rd}, {e.rn, e.ri, e.rd});
    end
  endtask

  // R8: registered unit shows inputs of the previous negedge at this negedge
  task automatic apply(logic v, logic [1:0] wf, logic [127:0] wd,
                       logic [1:0] rf, logic [127:0] rd);
    @(negedge clk);
    compare_pending();
    wr_valid = v; wr_fmt = wf; wr_data = wd; rd_fmt = rf; rd_data = rd;
    exp_n.push_back(model(64, 1'b0));
    exp_q.push_back(model(128, 1'b1));
  endtask

  localparam logic [127:0] PAT = 128'h0123456789ABCDEF_FEDCBA9876543210;
  localparam logic [127:0] BOX_S = {96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'h3F800000};
  localparam logic [127:0] BOX_D = {64'hFFFFFFFF_FFFFFFFF, 64'h400921FB54442D18};

  initial begin
    wr_valid = 1'b1; wr_fmt = 2'd0; wr_data = PAT; rd_fmt = 2'd0; rd_data = PAT;
    repeat (3) @(negedge clk);
    chk("R8", "reset outputs", {n_wv, n_wi, n_rn, n_ri, n_wd, n_rd}, '0);
    rst_n = 1'b1;

    apply(1'b1, 2'd0, PAT, 2'd0, BOX_S);                      // R1, R3
    apply(1'b1, 2'd1, PAT, 2'd0, BOX_S & ~(128'd1 << 40));    // R2/R1, R4
    apply(1'b1, 2'd0, PAT, 2'd0, BOX_S & ~(128'd1 << 100));   // R3 at 64, R4 at 128
    apply(1'b1, 2'd2, PAT, 2'd1, BOX_D);                      // R6 at 64, R5/R3
    apply(1'b0, 2'd1, PAT, 2'd1, BOX_D & ~(128'd1 << 127));   // R7, R5 at 64, R4 at 128
    apply(1'b1, 2'd3, PAT, 2'd3, PAT);                        // R6 reserved
    apply(1'b1, 2'd0, '0, 2'd0, '0);                          // R4 single NaN
    apply(1'b1, 2'd2, '1, 2'd2, PAT);                         // R6 at 64, R2/R5 at 128
    apply(1'b0, 2'd0, '1, 2'd1, '1);                          // R7, R3
    apply(1'b1, 2'd1, PAT, 2'd0, BOX_S & ~(128'd1 << 32));    // R4 lowest box bit
    apply(1'b1, 2'd1, PAT, 2'd0, BOX_S & ~(128'd1 << 63));    // R4 top of 64
    apply(1'b1, 2'd0, PAT, 2'd1, BOX_D & ~(128'd1 << 64));    // R5 at 64, R4 at 128

    for (int k = 0; k < 400; k++) begin
      logic [1:0]   wf, rf;
      logic [127:0] wd, rd;
      wf = 2'($urandom_range(0, 3));
      rf = 2'($urandom_range(0, 3));
      wd = {$urandom, $urandom, $urandom, $urandom};
      rd = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 1) == 1 && width_of(rf) > 0)
        rd = rd | ~ones_below(width_of(rf));
      if ($urandom_range(0, 3) == 0)
        rd = rd & ~(128'd1 << $urandom_range(32, 127));
      apply(1'($urandom_range(0, 1)), wf, wd, rf, rd);
    end

    @(negedge clk);
    compare_pending();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule